// File: doc/BRIEF.md
# Command/Response Buffer Status Engine

This block is the device-side sequencer that sits behind a byte-wide status register and a byte-wide data port. A host fills a shared buffer with a command one byte at a time. The block reads the total command length out of the command header and reports through a status bit whether it still expects bytes. A go request then hands the buffered command to an execution backend through a simple start/done handshake. While the backend owns the buffer, it reads the command and writes the response in place. The host then drains the response byte by byte, and a data-available bit reports whether response bytes remain.

Each command and each response starts with a 10-byte header. Header bytes 2 through 5 carry the total length as a 32-bit big-endian number. A 16-bit burst count tells the host how many bytes it may move without polling again. A command-ready request aborts whatever is in progress, from any state. The buffer depth and the address width are parameters. The buffer is one simple dual-port memory with a registered read, written so that block RAM can be inferred.

Top module: `crb_engine`

## Requirements
- R1: After reset the status byte reads 0x80 (only status-valid set) and both burst bytes read 0x00. The block accepts no command bytes until a command-ready request.
- R2: The status byte is at offset 0x18 with bit 7 status-valid, bit 6 command-ready, bit 5 go (always reads 0), bit 4 data-available and bit 3 data-expect. Bits 2..0 read 0. The burst count is little-endian at 0x19 (low) and 0x1A (high), and the data port is at 0x24. Read data appears on the cycle after the read strobe.
- R3: In the ready state a data-port write stores byte 0 and enters the receiving state. Later writes fill consecutive buffer positions in arrival order.
- R4: Header bytes 2..5 form a big-endian command length. Data-expect reads 1 while fewer than 10 bytes, or fewer bytes than that length, have arrived, and reads 0 once the last byte is in.
- R5: Data-port writes are dropped outside the ready and receiving states and after data-expect has cleared. They change neither the byte count handed to the backend nor the burst count.
- R6: A go write (status bit 5, bit 6 clear) while receiving with data-expect clear gives a one-cycle exec_start pulse and sets exec_cmd_len to the received byte count. The backend reads the buffer through exec_raddr/exec_rdata with one cycle of latency, and status-valid reads 0 during execution. A go write while data-expect is set is ignored.
- R7: While executing, backend writes go into the buffer, and its bytes 2..5 form the big-endian response length. On exec_done, status-valid and data-available read 1 together.
- R8: Data-port reads return the response bytes in order. Data-available reads 0 after the last one, and further reads return 0x00.
- R9: The burst count is the buffer depth in the ready state. While receiving it is depth minus bytes received, or 0 once no more bytes are accepted. While completing it is the response bytes still unread. In all other states it is 0.
- R10: A status write with bit 6 set returns the block to the ready state from any state, clearing the byte counts and both length fields. It takes priority over a go bit set in the same write.
- R11: When the command length exceeds the buffer depth, bytes past the depth are dropped, data-expect stays set and go is refused. A response length above the depth is clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Host byte address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid the cycle after reg_rd |
| exec_start | output | 1 | One-cycle pulse: command handed to backend |
| exec_cmd_len | output | CW | Number of command bytes in the buffer |
| exec_raddr | input | AW | Backend buffer read address |
| exec_rdata | output | 8 | Backend buffer read data, one cycle latency |
| exec_we | input | 1 | Backend buffer write enable (executing only) |
| exec_waddr | input | AW | Backend buffer write address |
| exec_wdata | input | 8 | Backend buffer write data |
| exec_done | input | 1 | Backend finished; response is in the buffer |

## Verification
The bench builds the block with DEPTH = 32 and ADDR_W = 8. A 32-byte buffer puts overflow within reach: a command whose header announces 40 bytes runs past the buffer end, and a response header announcing 256 bytes exercises the clamp. With this depth the high burst byte always reads zero, so the bench checks it only as zero. A full path runs command fill, go, backend access, response drain and abort. Along that path, go is tried early, a write is attempted during execution, and the bench reads past the end of the response.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_COMPL = 3'd4
  } crb_state_e;

  localparam int unsigned HDR_BYTES = 10;
  localparam int unsigned OFS_STS   = 'h18;
  localparam int unsigned OFS_FIFO  = 'h24;

  localparam int unsigned B_VALID  = 7;
  localparam int unsigned B_READY  = 6;
  localparam int unsigned B_GO     = 5;
  localparam int unsigned B_AVAIL  = 4;
  localparam int unsigned B_EXPECT = 3;
endpackage

// File: rtl/crb_ram.sv
module crb_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/crb_len_cap.sv
module crb_len_cap #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    data,
  output logic [31:0]   len
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len <= '0;
    end else if (we) begin
      case (idx)
        AW'(2):  len[31:24] <= data;
        AW'(3):  len[23:16] <= data;
        AW'(4):  len[15:8]  <= data;
        AW'(5):  len[7:0]   <= data;
        default: len <= len;
      endcase
    end
  end
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              start,
  output logic [CW-1:0]     cmd_count,
  input  logic [AW-1:0]     be_raddr,
  input  logic              be_we,
  input  logic [AW-1:0]     be_waddr,
  input  logic [7:0]        be_wdata,
  input  logic              be_done,
  input  logic [31:0]       cmd_len,
  input  logic [31:0]       rsp_len,
  output logic              cmd_len_clr,
  output logic              cmd_len_we,
  output logic              rsp_len_clr,
  output logic              rsp_len_we,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic [AW-1:0]     ram_raddr,
  input  logic [7:0]        ram_q
);
  crb_state_e    state_q;
  logic [CW-1:0] wr_cnt_q, rd_cnt_q;
  logic          fifo_sel_q;
  logic [7:0]    reg_q;

  logic          sts_wr, abort, go, fifo_wr, fifo_rd;
  logic          expect_c, room_c, accept, go_ok, avail_c, host_take;
  logic [CW-1:0] rsp_lim;
  logic [7:0]    sts_c;
  logic [15:0]   burst_c;

  assign sts_wr  = host_wr && (host_addr == ADDR_W'(OFS_STS));
  assign abort   = sts_wr && host_wdata[B_READY];
  assign go      = sts_wr && host_wdata[B_GO] && !host_wdata[B_READY];
  assign fifo_wr = host_wr && (host_addr == ADDR_W'(OFS_FIFO));
  assign fifo_rd = host_rd && (host_addr == ADDR_W'(OFS_FIFO));

  assign expect_c = (wr_cnt_q < CW'(HDR_BYTES)) || (32'(wr_cnt_q) < cmd_len);
  assign room_c   = wr_cnt_q < CW'(DEPTH);
  assign accept   = fifo_wr && !abort &&
                    ((state_q == ST_READY) ||
                     (state_q == ST_RECV && expect_c && room_c));
  assign go_ok    = go && (state_q == ST_RECV) && !expect_c;

  assign rsp_lim   = (rsp_len > 32'(DEPTH)) ? CW'(DEPTH) : CW'(rsp_len);
  assign avail_c   = (state_q == ST_COMPL) && (rd_cnt_q < rsp_lim);
  assign host_take = fifo_rd && avail_c && !abort;

  // buffer ports: host owns them outside execution, backend inside
  assign ram_we    = accept || (state_q == ST_EXEC && be_we);
  assign ram_waddr = accept ? wr_cnt_q[AW-1:0] : be_waddr;
  assign ram_wdata = accept ? host_wdata : be_wdata;
  assign ram_raddr = (state_q == ST_EXEC) ? be_raddr : rd_cnt_q[AW-1:0];

  assign cmd_len_clr = abort;
  assign cmd_len_we  = accept;
  assign rsp_len_clr = abort || go_ok;
  assign rsp_len_we  = (state_q == ST_EXEC) && be_we;
  assign cmd_count   = wr_cnt_q;

  always_comb begin
    sts_c           = '0;
    sts_c[B_VALID]  = (state_q != ST_EXEC);
    sts_c[B_READY]  = (state_q == ST_READY);
    sts_c[B_AVAIL]  = avail_c;
    sts_c[B_EXPECT] = (state_q == ST_RECV) && expect_c;
  end

  always_comb begin
    case (state_q)
      ST_READY: burst_c = 16'(DEPTH);
      ST_RECV:  burst_c = (expect_c && room_c) ? 16'(DEPTH) - 16'(wr_cnt_q) : 16'd0;
      ST_COMPL: burst_c = avail_c ? 16'(rsp_lim) - 16'(rd_cnt_q) : 16'd0;
      default:  burst_c = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      start    <= 1'b0;
    end else begin
      start <= 1'b0;
      if (abort) begin
        state_q  <= ST_READY;
        wr_cnt_q <= '0;
        rd_cnt_q <= '0;
      end else begin
        case (state_q)
          ST_READY: if (accept) begin
            state_q  <= ST_RECV;
            wr_cnt_q <= CW'(1);
          end
          ST_RECV: begin
            if (accept) wr_cnt_q <= wr_cnt_q + CW'(1);
            if (go_ok) begin
              state_q <= ST_EXEC;
              start   <= 1'b1;
            end
          end
          ST_EXEC: if (be_done) begin
            state_q  <= ST_COMPL;
            rd_cnt_q <= '0;
          end
          ST_COMPL: if (host_take) rd_cnt_q <= rd_cnt_q + CW'(1);
          default: state_q <= state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_sel_q <= 1'b0;
      reg_q      <= '0;
    end else begin
      fifo_sel_q <= host_take;
      if (host_rd && host_addr == ADDR_W'(OFS_STS))
        reg_q <= sts_c;
      else if (host_rd && host_addr == ADDR_W'(OFS_STS + 1))
        reg_q <= burst_c[7:0];
      else if (host_rd && host_addr == ADDR_W'(OFS_STS + 2))
        reg_q <= burst_c[15:8];
      else
        reg_q <= '0;
    end
  end

  assign host_rdata = fifo_sel_q ? ram_q : reg_q;

  AST_WR_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_q <= CW'(DEPTH)); // R11
  AST_ABORT_READY: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state_q == ST_READY && wr_cnt_q == '0)); // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R6
  AST_START_EXEC: assert property (@(posedge clk) disable iff (rst)
    start |-> state_q == ST_EXEC); // R6
  AST_DROP_EXEC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && fifo_wr && !abort) |=> $stable(wr_cnt_q)); // R5
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COMPL) |-> rd_cnt_q <= rsp_lim); // R8
endmodule

// File: rtl/crb_engine.sv
module crb_engine #(
  parameter int ADDR_W = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              exec_start,
  output logic [CW-1:0]     exec_cmd_len,
  input  logic [AW-1:0]     exec_raddr,
  output logic [7:0]        exec_rdata,
  input  logic              exec_we,
  input  logic [AW-1:0]     exec_waddr,
  input  logic [7:0]        exec_wdata,
  input  logic              exec_done
);
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_q;
  logic [31:0]   cmd_len, rsp_len;
  logic          cmd_clr, cmd_we, rsp_clr, rsp_we;

  crb_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  crb_len_cap #(.DEPTH(DEPTH)) u_cmd_len (
    .clk(clk), .rst(rst), .clr(cmd_clr), .we(cmd_we),
    .idx(ram_waddr), .data(ram_wdata), .len(cmd_len)
  );

  crb_len_cap #(.DEPTH(DEPTH)) u_rsp_len (
    .clk(clk), .rst(rst), .clr(rsp_clr), .we(rsp_we),
    .idx(exec_waddr), .data(exec_wdata), .len(rsp_len)
  );

  crb_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .host_addr(reg_addr), .host_wr(reg_wr), .host_rd(reg_rd),
    .host_wdata(reg_wdata), .host_rdata(reg_rdata),
    .start(exec_start), .cmd_count(exec_cmd_len),
    .be_raddr(exec_raddr), .be_we(exec_we), .be_waddr(exec_waddr),
    .be_wdata(exec_wdata), .be_done(exec_done),
    .cmd_len(cmd_len), .rsp_len(rsp_len),
    .cmd_len_clr(cmd_clr), .cmd_len_we(cmd_we),
    .rsp_len_clr(rsp_clr), .rsp_len_we(rsp_we),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_q(ram_q)
  );

  assign exec_rdata = ram_q;
endmodule

// File: tb/crb_engine_test.sv
`timescale 1ns/1ps
module crb_engine_test;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] A_STS = 8'h18, A_BLO = 8'h19, A_BHI = 8'h1A, A_FIFO = 8'h24;

  logic clk = 0, rst = 1;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_rdata;
  logic exec_start;
  logic [CW-1:0] exec_cmd_len;
  logic [AW-1:0] exec_raddr = 0, exec_waddr = 0;
  logic [7:0] exec_rdata, exec_wdata = 0;
  logic exec_we = 0, exec_done = 0;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  crb_engine #(.ADDR_W(8), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exec_start(exec_start),
    .exec_cmd_len(exec_cmd_len), .exec_raddr(exec_raddr), .exec_rdata(exec_rdata),
    .exec_we(exec_we), .exec_waddr(exec_waddr), .exec_wdata(exec_wdata),
    .exec_done(exec_done)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: pops the expected byte for each read as its data appears
  always @(posedge clk) pend <= reg_rd && !rst;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic be_wr(input int a, input logic [7:0] d);
    @(negedge clk); exec_waddr = AW'(a); exec_wdata = d; exec_we = 1;
    @(negedge clk); exec_we = 0;
  endtask

  task automatic be_rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk); exec_raddr = AW'(a);
    @(negedge clk); chk(exec_rdata, exp, tag);
  endtask

  task automatic be_finish();
    @(negedge clk); exec_done = 1;
    @(negedge clk); exec_done = 0;
  endtask

  function automatic logic [7:0] cmd_byte(int i, int len);
    case (i)
      2: return 8'((len >> 24) & 255);
      3: return 8'((len >> 16) & 255);
      4: return 8'((len >> 8) & 255);
      5: return 8'(len & 255);
      default: return 8'(i * 13 + 1);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(A_STS, 8'h80, "R1 status after reset");
    rd(A_BLO, 8'h00, "R1 burst low after reset");
    rd(A_BHI, 8'h00, "R1 burst high after reset");
    // R5 write in idle dropped
    wr(A_FIFO, 8'h55);
    rd(A_STS, 8'h80, "R5 idle write dropped status");
    rd(A_BLO, 8'h00, "R5 idle write dropped burst");
    // R10 / R2 enter ready
    wr(A_STS, 8'h40);
    rd(A_STS, 8'hC0, "R2 ready status bits");
    rd(A_BLO, 8'(DEPTH), "R9 burst in ready");
    // R3 / R4 command of 12 bytes
    wr(A_FIFO, cmd_byte(0, 12));
    rd(A_STS, 8'h88, "R3 receiving after first byte");
    rd(A_BLO, 8'(DEPTH - 1), "R9 burst after one byte");
    for (int i = 1; i < 5; i++) wr(A_FIFO, cmd_byte(i, 12));
    wr(A_STS, 8'h20);
    rd(A_STS, 8'h88, "R6 early go ignored");
    for (int i = 5; i < 11; i++) wr(A_FIFO, cmd_byte(i, 12));
    rd(A_STS, 8'h88, "R4 expect held before last byte");
    wr(A_FIFO, cmd_byte(11, 12));
    rd(A_STS, 8'h80, "R4 expect clear after last byte");
    rd(A_BLO, 8'h00, "R9 burst zero when full command");
    wr(A_FIFO, 8'hEE);
    // R6 go
    wr(A_STS, 8'h20);
    chk(8'(exec_start), 8'h01, "R6 exec_start pulse");
    chk(8'(exec_cmd_len), 8'd12, "R5 R6 command byte count");
    @(negedge clk);
    chk(8'(exec_start), 8'h00, "R6 exec_start single cycle");
    rd(A_STS, 8'h00, "R6 status invalid while executing");
    wr(A_FIFO, 8'h77);
    chk(8'(exec_cmd_len), 8'd12, "R5 write during exec dropped");
    be_rd(0, cmd_byte(0, 12), "R6 backend reads byte 0");
    be_rd(5, 8'h0C, "R6 backend reads length byte");
    be_rd(11, cmd_byte(11, 12), "R6 backend reads last byte");
    // R7 response of 14 bytes
    for (int i = 0; i < 14; i++) be_wr(i, cmd_byte(i, 14) ^ 8'h5A ^ ((i >= 2 && i <= 5) ? 8'h5A : 8'h00));
    be_finish();
    rd(A_STS, 8'h90, "R7 valid and avail together");
    rd(A_BLO, 8'd14, "R9 burst is response size");
    for (int i = 0; i < 14; i++) begin
      rd(A_FIFO, cmd_byte(i, 14) ^ 8'h5A ^ ((i >= 2 && i <= 5) ? 8'h5A : 8'h00), "R8 response byte");
      if (i == 12) rd(A_BLO, 8'd1, "R9 burst one left");
    end
    rd(A_STS, 8'h80, "R8 avail clear after drain");
    rd(A_BLO, 8'h00, "R9 burst zero after drain");
    rd(A_FIFO, 8'h00, "R8 read past end");
    // R10 abort priority over go, abort mid-receive
    wr(A_STS, 8'h60);
    rd(A_STS, 8'hC0, "R10 abort wins over go");
    for (int i = 0; i < 3; i++) wr(A_FIFO, cmd_byte(i, 12));
    wr(A_STS, 8'h40);
    rd(A_STS, 8'hC0, "R10 abort mid receive");
    rd(A_BLO, 8'(DEPTH), "R10 burst restored");
    // R11 overflow, 40-byte command
    for (int i = 0; i < 40; i++) wr(A_FIFO, cmd_byte(i, 40));
    rd(A_STS, 8'h88, "R11 expect held on overflow");
    rd(A_BLO, 8'h00, "R11 burst zero when full");
    wr(A_STS, 8'h20);
    rd(A_STS, 8'h88, "R11 go refused on overflow");
    // R11 response clamp
    wr(A_STS, 8'h40);
    for (int i = 0; i < 10; i++) wr(A_FIFO, cmd_byte(i, 10));
    rd(A_STS, 8'h80, "R4 ten byte command complete");
    wr(A_STS, 8'h20);
    chk(8'(exec_cmd_len), 8'd10, "R6 command count ten");
    for (int i = 0; i < 6; i++) be_wr(i, cmd_byte(i, 256));
    be_finish();
    rd(A_STS, 8'h90, "R7 avail after clamp response");
    rd(A_BLO, 8'(DEPTH), "R11 burst clamped low");
    rd(A_BHI, 8'h00, "R11 burst clamped high");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule